// File: doc/BRIEF.md
# Banked Memory Mapper

This block translates the 16-bit addresses of an 8-bit processor into a wider physical address space, in 4 KiB slots. Sixteen mapping registers, one per slot, each hold an 8-bit bank number. When translation is active, the top four CPU address bits pick a register. That register's bank number replaces those four bits, so the physical address is the bank number followed by the 12-bit offset. Bank numbers 0x00 to 0x0F point back into the host machine's own memory. Larger numbers point into expansion memory, and the `host_sel` output tells the memory system which side to use.

Translation is governed by an enable bit in a control latch at a fixed I/O address. After reset the bit is clear and every address passes straight through, so the machine behaves as though no mapper were fitted. Software fills the mapping registers through a 16-byte window in the I/O page and then sets the enable bit. The I/O page (0xEF00 to 0xEFFF) is never translated, so the latch and the window can always be reached. There is no write protection: all eight register bits form part of the physical address. The latch and registers are clocked storage; decoding and translation are combinational.

Top module: `banked_mmu`

## Requirements
- R1: A synchronous reset clears the control latch, so `map_active` reads 0 in the cycle after reset. It also loads every mapping register with its own slot number, so enabling translation without programming gives an identity mapping.
- R2: A write (`cpu_we`=1) to address 0xEFFC loads the control latch at the clock edge. Bit 4 of the written byte is the enable bit and appears on `map_active` from the next cycle. A write to any other address, or a cycle with `cpu_we`=0, leaves `map_active` unchanged.
- R3: While `map_active` is 0, `phys_addr` equals `cpu_addr` zero-extended to 20 bits and `host_sel` is 1.
- R4: While `map_active` is 1 and the address is outside the I/O page, `phys_addr[19:12]` equals the mapping register selected by `cpu_addr[15:12]`, and `phys_addr[11:0]` equals `cpu_addr[11:0]`.
- R5: A write to address 0xEFE0+i (i from 0 to 15) loads mapping register i with the written byte at the clock edge, and later translations use the new value. The write is stored even while translation is disabled.
- R6: While translating, `host_sel` is 1 when the selected bank number is 0x0F or below, and 0 when it is 0x10 or above.
- R7: Addresses 0xEF00 to 0xEFFF are never translated: `phys_addr` is the zero-extended `cpu_addr` and `host_sel` is 1, whatever the latch holds.
- R8: Writes that hit neither the latch nor the register window leave every mapping register unchanged. This includes other addresses in the I/O page.
- R9: All eight bits of a mapping register reach the physical address, so bank 0xFF produces `phys_addr[19:12]` = 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_we | input | 1 | Write strobe for the latch and the mapping registers |
| cpu_wdata | input | 8 | Processor write data |
| phys_addr | output | 20 | Translated physical address |
| host_sel | output | 1 | 1 selects host memory, 0 selects expansion memory |
| map_active | output | 1 | Current state of the enable bit |

## Verification
On every cycle, the assertions check the invariant properties of translation:
- flat pass-through while disabled;
- the I/O page exemption;
- the offset bits always passing through;
- `host_sel` agreeing with the bank field of the output;
- the latch loading only on its own address and otherwise holding.

Other behaviour needs stored history that a single-cycle property cannot see, so only the bench scenarios show it:
- which register value each slot actually returns;
- registers keeping writes made while disabled;
- stray writes leaving the registers untouched;
- reset restoring the identity mapping.

The bench shows these by sweeping all sixteen slots against a model of the register contents.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int DEF_CPU_AW     = 16;
    localparam int DEF_DATA_W     = 8;
    localparam int DEF_SLOT_BITS  = 4;
    localparam int DEF_BANK_W     = 8;
    localparam int DEF_HOST_BANKS = 16;
    localparam int DEF_EN_BIT     = 4;
    localparam int PAGE_TAG_W     = 8;

    localparam logic [DEF_CPU_AW-1:0] DEF_LATCH_ADDR = 16'hEFFC;
    localparam logic [DEF_CPU_AW-1:0] DEF_WIN_BASE   = 16'hEFE0;
    localparam logic [PAGE_TAG_W-1:0] DEF_IO_PAGE    = 8'hEF;

    // I/O decode result for one CPU cycle
    typedef struct packed {
        logic io_page;
        logic latch_hit;
        logic win_hit;
    } io_dec_t;

    // Which path the address took through the translator
    typedef enum logic [1:0] {
        PATH_FLAT   = 2'd0,
        PATH_IO     = 2'd1,
        PATH_BANKED = 2'd2
    } path_t;

    // Bank numbers below the host limit stay on the host machine
    function automatic logic is_host_bank(input logic [DEF_BANK_W-1:0] bank,
                                          input int unsigned limit);
        return int'(bank) < int'(limit);
    endfunction

endpackage

// File: rtl/mmu_io_decode.sv
module mmu_io_decode
    import mmu_pkg::*;
#(
    parameter int                CPU_AW     = DEF_CPU_AW,
    parameter int                SLOT_BITS  = DEF_SLOT_BITS,
    parameter logic [CPU_AW-1:0] LATCH_ADDR = DEF_LATCH_ADDR,
    parameter logic [CPU_AW-1:0] WIN_BASE   = DEF_WIN_BASE,
    parameter logic [PAGE_TAG_W-1:0] IO_PAGE = DEF_IO_PAGE
) (
    input  logic [CPU_AW-1:0]    cpu_addr,
    output io_dec_t              dec,
    output logic [SLOT_BITS-1:0] win_idx
);

    localparam int PAGE_LSB = CPU_AW - PAGE_TAG_W;

    always_comb begin
        dec.io_page   = (cpu_addr[CPU_AW-1:PAGE_LSB] == IO_PAGE);
        dec.latch_hit = (cpu_addr == LATCH_ADDR);
        dec.win_hit   = (cpu_addr[CPU_AW-1:SLOT_BITS] == WIN_BASE[CPU_AW-1:SLOT_BITS]);
        win_idx       = cpu_addr[SLOT_BITS-1:0];
    end

endmodule

// File: rtl/mmu_regfile.sv
module mmu_regfile
    import mmu_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int SLOT_BITS = DEF_SLOT_BITS,
    parameter int BANK_W    = DEF_BANK_W,
    parameter int EN_BIT    = DEF_EN_BIT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_we,
    input  io_dec_t              dec,
    input  logic [SLOT_BITS-1:0] win_idx,
    input  logic [DATA_W-1:0]    cpu_wdata,
    input  logic [SLOT_BITS-1:0] slot_sel,
    output logic                 map_en,
    output logic [BANK_W-1:0]    bank
);

    localparam int NSLOT = 1 << SLOT_BITS;

    logic [DATA_W-1:0] latch_q;
    logic [BANK_W-1:0] bank_q [NSLOT];

    // Control latch
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else if (cpu_we && dec.latch_hit) begin
            latch_q <= cpu_wdata;
        end
    end

    assign map_en = latch_q[EN_BIT];

    // One mapping register per slot, reset to identity
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [BANK_W-1:0] RST_BANK = BANK_W'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[g] <= RST_BANK;
            end else if (cpu_we && dec.win_hit && (win_idx == SLOT_BITS'(g))) begin
                bank_q[g] <= cpu_wdata[BANK_W-1:0];
            end
        end
    end

    assign bank = bank_q[slot_sel];

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_pkg::*;
#(
    parameter int CPU_AW     = DEF_CPU_AW,
    parameter int SLOT_BITS  = DEF_SLOT_BITS,
    parameter int BANK_W     = DEF_BANK_W,
    parameter int HOST_BANKS = DEF_HOST_BANKS
) (
    input  logic [CPU_AW-1:0]                    cpu_addr,
    input  logic                                 map_en,
    input  logic                                 io_page,
    input  logic [BANK_W-1:0]                    bank,
    output logic [BANK_W+CPU_AW-SLOT_BITS-1:0]   phys_addr,
    output logic                                 host_sel,
    output path_t                                path
);

    localparam int OFF_W = CPU_AW - SLOT_BITS;
    localparam int PA_W  = BANK_W + OFF_W;

    always_comb begin
        if (!map_en) begin
            path = PATH_FLAT;
        end else if (io_page) begin
            path = PATH_IO;
        end else begin
            path = PATH_BANKED;
        end

        unique case (path)
            PATH_BANKED: begin
                phys_addr = {bank, cpu_addr[OFF_W-1:0]};
                host_sel  = is_host_bank(DEF_BANK_W'(bank), HOST_BANKS);
            end
            default: begin
                phys_addr = PA_W'(cpu_addr);
                host_sel  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/banked_mmu.sv
module banked_mmu
    import mmu_pkg::*;
#(
    parameter int                CPU_AW     = DEF_CPU_AW,
    parameter int                DATA_W     = DEF_DATA_W,
    parameter int                SLOT_BITS  = DEF_SLOT_BITS,
    parameter int                BANK_W     = DEF_BANK_W,
    parameter int                HOST_BANKS = DEF_HOST_BANKS,
    parameter int                EN_BIT     = DEF_EN_BIT,
    parameter logic [CPU_AW-1:0] LATCH_ADDR = DEF_LATCH_ADDR,
    parameter logic [CPU_AW-1:0] WIN_BASE   = DEF_WIN_BASE,
    parameter logic [PAGE_TAG_W-1:0] IO_PAGE = DEF_IO_PAGE,
    localparam int               PA_W       = BANK_W + CPU_AW - SLOT_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [PA_W-1:0]   phys_addr,
    output logic              host_sel,
    output logic              map_active
);

    io_dec_t              dec;
    logic [SLOT_BITS-1:0] win_idx;
    logic [BANK_W-1:0]    bank;
    logic                 map_en;
    path_t                path;

    mmu_io_decode #(
        .CPU_AW    (CPU_AW),
        .SLOT_BITS (SLOT_BITS),
        .LATCH_ADDR(LATCH_ADDR),
        .WIN_BASE  (WIN_BASE),
        .IO_PAGE   (IO_PAGE)
    ) u_dec (
        .cpu_addr(cpu_addr),
        .dec     (dec),
        .win_idx (win_idx)
    );

    mmu_regfile #(
        .DATA_W   (DATA_W),
        .SLOT_BITS(SLOT_BITS),
        .BANK_W   (BANK_W),
        .EN_BIT   (EN_BIT)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cpu_we   (cpu_we),
        .dec      (dec),
        .win_idx  (win_idx),
        .cpu_wdata(cpu_wdata),
        .slot_sel (cpu_addr[CPU_AW-1 -: SLOT_BITS]),
        .map_en   (map_en),
        .bank     (bank)
    );

    mmu_xlate #(
        .CPU_AW    (CPU_AW),
        .SLOT_BITS (SLOT_BITS),
        .BANK_W    (BANK_W),
        .HOST_BANKS(HOST_BANKS)
    ) u_xlate (
        .cpu_addr (cpu_addr),
        .map_en   (map_en),
        .io_page  (dec.io_page),
        .bank     (bank),
        .phys_addr(phys_addr),
        .host_sel (host_sel),
        .path     (path)
    );

    assign map_active = map_en;

endmodule

// File: rtl/mmu_checker.sv
module mmu_checker #(
    parameter int CPU_AW     = 16,
    parameter int SLOT_BITS  = 4,
    parameter int BANK_W     = 8,
    parameter int DATA_W     = 8,
    parameter int HOST_BANKS = 16,
    parameter int EN_BIT     = 4,
    parameter logic [CPU_AW-1:0] LATCH_ADDR = 16'hEFFC,
    parameter logic [7:0]        IO_PAGE    = 8'hEF,
    localparam int PA_W  = BANK_W + CPU_AW - SLOT_BITS,
    localparam int OFF_W = CPU_AW - SLOT_BITS
) (
    input logic              clk,
    input logic              rst,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic              cpu_we,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [PA_W-1:0]   phys_addr,
    input logic              host_sel,
    input logic              map_active
);

    logic in_io;
    logic latch_wr;
    assign in_io    = (cpu_addr[CPU_AW-1 -: 8] == IO_PAGE);
    assign latch_wr = cpu_we && (cpu_addr == LATCH_ADDR);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> !map_active);                                        // R1

    AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
        latch_wr |=> (map_active == $past(cpu_wdata[EN_BIT])));             // R2

    AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (rst)
        !latch_wr |=> $stable(map_active));                                 // R2

    AST_FLAT_PASS: assert property (@(posedge clk) disable iff (rst)
        !map_active |-> (phys_addr == PA_W'(cpu_addr)) && host_sel);        // R3

    AST_IO_PASS: assert property (@(posedge clk) disable iff (rst)
        in_io |-> (phys_addr == PA_W'(cpu_addr)) && host_sel);              // R7

    AST_HOST_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (map_active && !in_io) |->
            (host_sel == (int'(phys_addr[PA_W-1 -: BANK_W]) < HOST_BANKS))); // R6

    AST_OFFSET_KEEP: assert property (@(posedge clk) disable iff (rst)
        phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);                        // R4

endmodule

bind banked_mmu mmu_checker #(
    .CPU_AW    (CPU_AW),
    .SLOT_BITS (SLOT_BITS),
    .BANK_W    (BANK_W),
    .DATA_W    (DATA_W),
    .HOST_BANKS(HOST_BANKS),
    .EN_BIT    (EN_BIT),
    .LATCH_ADDR(LATCH_ADDR),
    .IO_PAGE   (IO_PAGE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_we    (cpu_we),
    .cpu_wdata (cpu_wdata),
    .phys_addr (phys_addr),
    .host_sel  (host_sel),
    .map_active(map_active)
);

// File: tb/banked_mmu_bench.sv
module banked_mmu_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [19:0] phys_addr;
    logic        host_sel;
    logic        map_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mdl_map [16];
    logic       mdl_en;

    always #10 clk = ~clk;

    banked_mmu u_banked_mmu (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_we    (cpu_we),
        .cpu_wdata (cpu_wdata),
        .phys_addr (phys_addr),
        .host_sel  (host_sel),
        .map_active(map_active)
    );

    task automatic model_reset();
        for (int i = 0; i < 16; i++) mdl_map[i] = 8'(i);
        mdl_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cpu_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_we    = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
        if (a == 16'hEFFC) mdl_en = d[4];
        else if (a[15:4] == 12'hEFE) mdl_map[a[3:0]] = d;
    endtask

    task automatic chk_active(input string req);
        @(negedge clk);
        #2;
        checks++;
        if (map_active !== mdl_en) begin
            errors++;
            $display("FAIL %s map_active actual=%0b expected=%0b", req, map_active, mdl_en);
        end
    endtask

    task automatic probe(input logic [15:0] a, input string req);
        logic [19:0] ep;
        logic        eh;
        @(negedge clk);
        cpu_we   = 1'b0;
        cpu_addr = a;
        #2;
        if (!mdl_en || a[15:8] == 8'hEF) begin
            ep = {4'h0, a};
            eh = 1'b1;
        end else begin
            ep = {mdl_map[a[15:12]], a[11:0]};
            eh = (mdl_map[a[15:12]] < 8'h10);
        end
        checks++;
        if (phys_addr !== ep || host_sel !== eh) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h/%0b expected=%h/%0b",
                     req, a, phys_addr, host_sel, ep, eh);
        end
    endtask

    task automatic sweep(input string req);
        for (int s = 0; s < 16; s++) begin
            probe({4'(s), 12'h000}, req);
            probe({4'(s), 12'h5A5}, req);
            probe({4'(s), 12'hFFF}, req);
        end
    endtask

    initial begin
        model_reset();
        do_reset();

        // R1 / R3: unmapped after reset, flat pass-through
        chk_active("R1");
        sweep("R3");

        // R2: enable, then R1 identity mapping
        wr(16'hEFFC, 8'h10);
        chk_active("R2");
        sweep("R1");

        // R5 / R4 / R6 / R9: program all slots
        for (int i = 0; i < 16; i++) wr(16'hEFE0 + 16'(i), 8'((i * 29 + 7) & 8'hFF));
        wr(16'hEFE2, 8'h0F);
        wr(16'hEFE3, 8'h10);
        wr(16'hEFEF, 8'hFF);
        sweep("R4");
        probe(16'h2ABC, "R6");
        probe(16'h3ABC, "R6");
        probe(16'hF123, "R9");

        // R7: I/O page left untouched while mapping
        probe(16'hEF00, "R7");
        probe(16'hEF80, "R7");
        probe(16'hEFFC, "R7");
        probe(16'hEFFF, "R7");

        // R8: stray writes, including in the I/O page, change nothing
        wr(16'hEFD5, 8'hAA);
        wr(16'hEFF5, 8'hBB);
        wr(16'h1234, 8'hCC);
        wr(16'hEFFD, 8'h00);
        chk_active("R2");
        sweep("R8");

        // R2: disable with other bits set, flat again
        wr(16'hEFFC, 8'hEF);
        chk_active("R2");
        sweep("R3");

        // R5: write while disabled is retained
        wr(16'hEFE5, 8'h40);
        wr(16'hEFE6, 8'h0C);
        probe(16'h5123, "R5");
        wr(16'hEFFC, 8'h10);
        chk_active("R2");
        probe(16'h5123, "R5");
        probe(16'h6FED, "R5");
        sweep("R5");

        // R1: reset restores unmapped state and identity registers
        do_reset();
        chk_active("R1");
        wr(16'hEFFC, 8'h10);
        sweep("R1");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule